// File: doc/BRIEF.md
# Dual-Bank Memory Reset Sequencer

This controller sits between the hardware reset pin of a two-bank flash-style memory and the rest of its control logic. The memory can read one bank while programming or erasing the other. While the reset pin is held low, the sequencer takes the data bus off the shared bus and marks every bank as not accessible. When the pin is released, each bank waits out its own recovery interval and then raises its own access flag. A bank that was idle when reset arrived gets the short interval. A bank whose program or erase was cut off gets the long interval.

The open-drain ready/busy pin is pulled low as long as any bank is still recovering. For each bank whose operation was aborted, a sticky flag records that the locations under operation now hold invalid data. Control logic clears that flag with a per-bank acknowledge once it has scheduled the rewrite. All intervals are counted in clock cycles and are derived from the clock frequency parameter. With the defaults (100 MHz) the short interval is 50 cycles (500 ns) and the long interval is 1100 cycles (11 µs). The reset pin is assumed to be synchronous to the clock. A separate synchronous power-on reset sets the initial state.

Top module: `dual_bank_reset_seq`

## Requirements
- R1: Any clock edge with the reset pin low clears every bank's access flag, and the flags are low in the following cycle. A new low level during recovery restarts every bank's count from zero.
- R2: The data bus enable is low in every cycle in which the reset pin is low, and in the first cycle after release. It is high in all other cycles.
- R3: Each bank's busy input is sampled only on the first clock edge of a reset-low period (the falling edge). Changes to busy at other times do not change that bank's recovery interval.
- R4: A bank that was idle at the falling edge raises its access flag after exactly SHORT_CYC clock edges with the pin high. SHORT_CYC is the ceiling of CLK_MHZ*500/1000.
- R5: A bank that was busy at the falling edge raises its access flag after exactly LONG_CYC clock edges with the pin high. LONG_CYC is the ceiling of CLK_MHZ*11000/1000.
- R6: If the pin falls again while a bank is still recovering from an aborted operation, that bank keeps the long interval, even though its busy input is now low.
- R7: The ready/busy pull-down output is 1 exactly when at least one bank access flag is 0.
- R8: A bank's abort flag is set at a falling edge where that bank's busy input is 1. It stays set until that bank's acknowledge is high on an edge with the pin high. An acknowledge while the pin is low is ignored.
- R9: After power-on reset, with the pin high, all access flags are 1, all abort flags are 0, the pull-down is 0 and the bus enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Synchronous active-low power-on reset |
| hw_rst_n | input | 1 | Memory hardware reset pin, active low, synchronous to clk |
| bank_busy_i | input | NUM_BANKS | Per-bank program/erase in progress |
| abort_ack_i | input | NUM_BANKS | Per-bank acknowledge that clears the abort flag |
| bank_ready_o | output | NUM_BANKS | Per-bank access permitted |
| abort_flag_o | output | NUM_BANKS | Per-bank sticky flag: operation aborted, data invalid |
| rb_pull_low_o | output | 1 | Drive the open-drain ready/busy pin low |
| dq_en_o | output | 1 | Data bus output drivers allowed |

## Verification
Most internal faults show up at the ports within a single interval. A wrong busy/idle classification moves a bank's access flag by a whole interval: the flag rises at the short count where the long count was due, or the reverse. A counter that fails to restart, or that stops one count off, moves the flag edge by one or more cycles, so the bench checks the access flags on every cycle of each recovery. A lost abort flag or a missed restart is visible on the first sample after release or after the acknowledge.

// File: rtl/drs_pkg.sv
// Shared types and timing helpers for the dual-bank reset sequencer.
// Assumes intervals are given in nanoseconds and the clock in whole MHz.
package drs_pkg;

    // Recovery state of one bank
    typedef enum logic [1:0] {
        BK_READY   = 2'd0,
        BK_HELD    = 2'd1,
        BK_RECOVER = 2'd2
    } bank_st_e;

    // Cycles needed to cover ns nanoseconds at mhz, rounded up, at least 1
    function automatic int cyc_for_ns(input int mhz, input int ns);
        int c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/drs_pin_sense.sv
// Samples the reset pin, detects its falling edge and gates the data bus.
// Assumes hw_rst_n is already synchronous to clk.
module drs_pin_sense (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pin_i,
    output logic fall_o,
    output logic dq_en_o
);
    logic pin_q;

    // Previous pin level; idles high so a pin low at start counts as a fall
    always_ff @(posedge clk) begin
        if (!sys_rst_n) pin_q <= 1'b1;
        else            pin_q <= pin_i;
    end

    assign fall_o  = pin_q & ~pin_i;
    assign dq_en_o = pin_q & pin_i;

    AST_FALL_ONLY_LOW: assert property (@(posedge clk) disable iff (!sys_rst_n) fall_o |=> !pin_q); // R3

endmodule

// File: rtl/drs_bank_timer.sv
// Recovery timer for one bank: classifies the bank at the pin's falling
// edge, holds it unavailable while the pin is low, then counts the short
// or long interval and raises the access flag. Also keeps the sticky
// abort flag. Assumes fall_i is high only in the first low cycle.
module drs_bank_timer
    import drs_pkg::*;
#(
    parameter int SHORT_CYC = 50,
    parameter int LONG_CYC  = 1100
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pin_i,
    input  logic fall_i,
    input  logic busy_i,
    input  logic ack_i,
    output logic ready_o,
    output logic abort_o
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

    bank_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             long_q;
    logic             abort_q;
    logic [CNT_W-1:0] last_cnt;

    // Final count value for the interval this bank was given
    assign last_cnt = long_q ? LONG_LAST : SHORT_LAST;

    // Hold, classify and count the recovery interval
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            st_q   <= BK_READY;
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (!pin_i) begin
            st_q  <= BK_HELD;
            cnt_q <= '0;
            if (fall_i)
                long_q <= busy_i | (long_q & (st_q != BK_READY));
        end else if (st_q != BK_READY) begin
            if (cnt_q == last_cnt) begin
                st_q  <= BK_READY;
                cnt_q <= '0;
            end else begin
                st_q  <= BK_RECOVER;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Sticky record that an operation was aborted by reset
    always_ff @(posedge clk) begin
        if (!sys_rst_n)             abort_q <= 1'b0;
        else if (fall_i && busy_i)  abort_q <= 1'b1;
        else if (pin_i && ack_i)    abort_q <= 1'b0;
    end

    assign ready_o = (st_q == BK_READY);
    assign abort_o = abort_q;

    AST_HELD_NOT_READY: assert property (@(posedge clk) disable iff (!sys_rst_n) !pin_i |=> !ready_o); // R1
    AST_CLASS_KEPT: assert property (@(posedge clk) disable iff (!sys_rst_n) $past(pin_i) && pin_i |-> $stable(long_q)); // R3
    AST_READY_NEEDS_PIN: assert property (@(posedge clk) disable iff (!sys_rst_n) ready_o && !$past(ready_o) |-> $past(pin_i)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!sys_rst_n) cnt_q <= LONG_LAST); // R5
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n) abort_o && !(pin_i && ack_i) |=> abort_o); // R8

endmodule

// File: rtl/drs_ready_merge.sv
// Merges the per-bank access flags into the open-drain ready/busy drive.
// Assumes a pulled-up external pin: output 1 means pull it low.
module drs_ready_merge #(
    parameter int NUM_BANKS = 2
) (
    input  logic [NUM_BANKS-1:0] ready_i,
    output logic                 pull_low_o
);
    // Busy while any bank is still unavailable
    always_comb begin
        pull_low_o = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (!ready_i[b]) pull_low_o = 1'b1;
    end

endmodule

// File: rtl/dual_bank_reset_seq.sv
// Reset sequencer for a multi-bank memory: tristates the data bus during
// reset and times each bank's recovery from the release of the pin.
// Assumes hw_rst_n is synchronous to clk and CLK_MHZ is the real rate.
module dual_bank_reset_seq
    import drs_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CLK_MHZ   = 100,
    parameter int IDLE_NS   = 500,
    parameter int ABORT_NS  = 11000
) (
    input  logic                 clk,
    input  logic                 sys_rst_n,
    input  logic                 hw_rst_n,
    input  logic [NUM_BANKS-1:0] bank_busy_i,
    input  logic [NUM_BANKS-1:0] abort_ack_i,
    output logic [NUM_BANKS-1:0] bank_ready_o,
    output logic [NUM_BANKS-1:0] abort_flag_o,
    output logic                 rb_pull_low_o,
    output logic                 dq_en_o
);
    localparam int SHORT_CYC = cyc_for_ns(CLK_MHZ, IDLE_NS);
    localparam int LONG_CYC  = cyc_for_ns(CLK_MHZ, ABORT_NS);

    logic pin_fall;

    drs_pin_sense u_pin (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .pin_i     (hw_rst_n),
        .fall_o    (pin_fall),
        .dq_en_o   (dq_en_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        drs_bank_timer #(
            .SHORT_CYC (SHORT_CYC),
            .LONG_CYC  (LONG_CYC)
        ) u_timer (
            .clk       (clk),
            .sys_rst_n (sys_rst_n),
            .pin_i     (hw_rst_n),
            .fall_i    (pin_fall),
            .busy_i    (bank_busy_i[b]),
            .ack_i     (abort_ack_i[b]),
            .ready_o   (bank_ready_o[b]),
            .abort_o   (abort_flag_o[b])
        );
    end

    drs_ready_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
        .ready_i    (bank_ready_o),
        .pull_low_o (rb_pull_low_o)
    );

    AST_BUS_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!sys_rst_n) !hw_rst_n |-> !dq_en_o); // R2
    AST_RB_FOLLOWS_BANKS: assert property (@(posedge clk) disable iff (!sys_rst_n) rb_pull_low_o == !(&bank_ready_o)); // R7

endmodule

// File: tb/dual_bank_reset_seq_tb.sv
`timescale 1ns/1ps
module dual_bank_reset_seq_tb_top;
    localparam int NB    = 2;
    localparam int MHZ   = 10;
    localparam int SHORT = (MHZ * 500 + 999) / 1000;
    localparam int LONG  = (MHZ * 11000 + 999) / 1000;

    logic          clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          hw_rst_n = 1'b1;
    logic [NB-1:0] busy = '0;
    logic [NB-1:0] ack = '0;
    logic [NB-1:0] ready;
    logic [NB-1:0] abort_f;
    logic          rb;
    logic          dq_en;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [NB-1:0] exp_abort = '0;

    always #2.5 clk = ~clk;

    dual_bank_reset_seq #(.NUM_BANKS(NB), .CLK_MHZ(MHZ)) dut_i (
        .clk(clk), .sys_rst_n(sys_rst_n), .hw_rst_n(hw_rst_n),
        .bank_busy_i(busy), .abort_ack_i(ack),
        .bank_ready_o(ready), .abort_flag_o(abort_f),
        .rb_pull_low_o(rb), .dq_en_o(dq_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Release the pin and follow every cycle of recovery
    task automatic release_and_track(input int lim0, input int lim1);
        hw_rst_n = 1'b1;
        #1 check("R2 enable low in first released cycle", dq_en, 0);
        for (int k = 1; k <= LONG + 2; k++) begin
            logic [NB-1:0] e;
            @(negedge clk);
            e[0] = (k >= lim0);
            e[1] = (k >= lim1);
            check("R4/R5 bank0 access timing", ready[0], e[0]);
            check("R4/R5 bank1 access timing", ready[1], e[1]);
            check("R7 pull-down tracks banks", rb, !(&e));
            check("R2 enable high after release", dq_en, 1);
        end
    endtask

    // Pulse the pin low with a busy pattern held for hold cycles
    task automatic pulse(input logic [NB-1:0] pat, input int hold);
        @(negedge clk);
        hw_rst_n = 1'b0;
        busy = pat;
        #1 check("R2 enable low during reset", dq_en, 0);
        @(negedge clk);
        busy = ~pat; // R3: changes after the falling edge must be ignored
        check("R1 banks blocked during reset", ready, 0);
        check("R7 pull-down during reset", rb, 1);
        repeat (hold - 1) @(negedge clk);
        check("R2 enable low while held", dq_en, 0);
        busy = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset banks ready", ready, 3);
        check("R9 reset abort clear", abort_f, 0);
        check("R9 reset pull-down off", rb, 0);
        check("R9 reset bus enabled", dq_en, 1);

        // Sweep every busy pattern and several hold lengths (R3 R4 R5 R8)
        for (int p = 0; p < 4; p++) begin
            for (int h = 1; h <= 3; h++) begin
                pulse(NB'(p), h);
                exp_abort = exp_abort | NB'(p);
                release_and_track(p[0] ? LONG : SHORT, p[1] ? LONG : SHORT);
                check("R8 abort flags set", abort_f, exp_abort);
                ack = 2'b11;
                @(negedge clk);
                ack = 2'b00;
                exp_abort = '0;
                check("R8 abort cleared by ack", abort_f, 0);
            end
        end

        // Re-assertion mid-recovery: bank0 keeps the long class (R1 R6 R8)
        pulse(2'b01, 2);
        hw_rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 idle bank ready early", ready[1], 1);
        check("R6 aborted bank still recovering", ready[0], 0);
        pulse(2'b00, 2);
        ack = 2'b11; // ignored while the pin is low
        @(negedge clk);
        ack = 2'b00;
        release_and_track(LONG, SHORT);
        check("R8 ack during reset ignored", abort_f, 2'b01);
        ack = 2'b01;
        @(negedge clk);
        ack = 2'b00;
        check("R8 abort cleared after release", abort_f, 0);

        // Fresh reset with no busy gives both banks the short interval (R1)
        pulse(2'b00, 1);
        release_and_track(SHORT, SHORT);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule